// File: doc/BRIEF.md
# ECC Memory Controller Register File

This block is the software-visible control and status register set of an ECC memory controller. It sits on a word-wide register bus and holds nine 32-bit registers: enable, delay, fault status, video configuration, two fault address registers, diagnostic, and two event counters. A build-time parameter picks one of three controller variants. The variant sets the enable-register write mask, the identification code returned in the enable register, and the bits that survive a reset.

A hardware fault-capture port, driven by the ECC checking datapath outside this block, loads the fault status and fault address registers. The same strobe raises an error interrupt. Firmware reads the captured fault and then clears the interrupt by writing the fault status register.

Variant 0 also has a 4-byte diagnostic window in the upper half of the address space. Software reaches it only with byte accesses.

Top module: `ecc_ctl_regs`

## Requirements
- R1: A register is selected by word index `bus_addr[11:2]` while `bus_addr[12]` is 0 and `bus_byte` is 0. The index map is: 0 enable, 1 delay, 2 fault status, 3 video configuration, 4 fault address 0, 5 fault address 1, 6 diagnostic, 7 event counter 0, 8 event counter 1. A read returns data combinationally in the same cycle. A write takes effect at the rising edge.
- R2: On variant 0, an enable write keeps only `wdata & 0x103`, and bits 31:28 read as zero. On variants 1 and 2, an enable write keeps `wdata & 0xBFF`, and bits 31:28 always read as the variant number (1 or 2).
- R3: A delay write stores bits 30:0 of the data and forces bit 31 to zero.
- R4: Any write to fault status stores the full 32-bit value and drives `irq` low from that edge on, unless a fault capture arrives in the same cycle.
- R5: Both fault address registers are read-only. Bus writes to index 4 or 5 leave their values unchanged.
- R6: Reset clears the stored enable bits except those retained by the variant. Variant 0 retains bit 8. Variants 1 and 2 retain bits 9:2 and bit 11, and bits 31:28 keep the variant code. Before the first write the stored bits power up as zero.
- R7: After reset, delay reads 0x20, fault address 0 reads 0x07C00000, and every other register and diagnostic byte reads zero. `irq` is low.
- R8: On variant 0, byte accesses with `bus_addr[12]`=1 and `bus_addr[11:2]`=0 reach a 4-entry byte store indexed by `bus_addr[1:0]`. Writes take `bus_wdata[7:0]`, and reads return the byte in `bus_rdata[7:0]` with the upper bits zero. Word accesses there are ignored and read zero. On variants 1 and 2 the whole window reads zero and ignores writes.
- R9: A `flt_valid` cycle loads fault status with: bit 0 = correctable (`!flt_ue`), bit 3 = `flt_ue`, bits 7:4 = `flt_dw`, bits 15:8 = `flt_synd`, bit 16 = multiple-error, and all other bits 0. It loads the address registers from `flt_addr0` and `flt_addr1`. A capture takes priority over a same-cycle status write.
- R10: The multiple-error bit of a capture is set when bit 0 or bit 3 of fault status was already set before that capture.
- R11: A capture raises `irq` if it is uncorrectable. It raises `irq` for a correctable fault only when enable bit 1 is set. Otherwise `irq` keeps its value.
- R12: The two event counter registers are independent, and each reads back its own last written value.
- R13: Reads of unmapped indices (9 and above), or of register space with `bus_byte`=1, return zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| flt_valid | input | 1 | Fault capture strobe |
| flt_ue | input | 1 | Captured fault is uncorrectable |
| flt_dw | input | 4 | Double-word index of the fault |
| flt_synd | input | 8 | Check syndrome of the fault |
| flt_addr0 | input | 32 | Value for fault address 0 |
| flt_addr1 | input | 32 | Value for fault address 1 |
| irq | output | 1 | Error interrupt |

## Verification
Read data is combinational, so it is due in the cycle the address is driven. The bench drives each read on a falling edge and samples 2 ns later, before the next rising edge. Writes, captures and reset act at the following rising edge, and `irq` is a register that changes at that same edge. The bench therefore updates its model when it drives the stimulus and compares registers and `irq` only from the next falling edge onward. Both a variant-0 and a variant-2 instance take the same bus traffic, so each check compares the two against their own expected values.

// File: rtl/ecc_regs_pkg.sv
// Package: register indices, reset values and per-variant masks for the
// ECC controller register file. Assumes variant codes 0, 1 or 2.
package ecc_regs_pkg;

    localparam int NUM_REGS = 9;
    localparam int IDX_EN   = 0;
    localparam int IDX_DLY  = 1;
    localparam int IDX_STS  = 2;
    localparam int IDX_VID  = 3;
    localparam int IDX_FA0  = 4;
    localparam int IDX_FA1  = 5;
    localparam int IDX_DIAG = 6;
    localparam int IDX_EV0  = 7;
    localparam int IDX_EV1  = 8;

    localparam logic [31:0] DLY_RESET = 32'h0000_0020;
    localparam logic [31:0] DLY_WMASK = 32'h7FFF_FFFF;
    localparam logic [31:0] FA0_RESET = 32'h07C0_0000;

    // Bits an enable write may store for the given variant.
    function automatic logic [31:0] en_write_mask(input int variant);
        return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    // Stored enable bits that survive reset for the given variant.
    function automatic logic [31:0] en_keep_mask(input int variant);
        return (variant == 0) ? 32'h0000_0100 : 32'h0000_0BFC;
    endfunction

    // Identification code placed in enable bits 31:28.
    function automatic logic [3:0] id_code(input int variant);
        return (variant == 0) ? 4'h0 : 4'(variant);
    endfunction

endpackage

// File: rtl/ecc_enable_reg.sv
// Enable register. Write masking, reset retention and the read-back
// identification field all depend on VARIANT. Assumes a synchronous
// active-low reset. The stored bits power up as zero.
module ecc_enable_reg
    import ecc_regs_pkg::*;
#(
    parameter int VARIANT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] q,
    output logic        ce_irq_en
);
    localparam logic [31:0] WMASK = en_write_mask(VARIANT);
    localparam logic [31:0] KEEP  = en_keep_mask(VARIANT);
    localparam logic [3:0]  ID    = id_code(VARIANT);

    logic [31:0] stored_q = '0;

    // Store the masked write, or keep only the retained bits on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored_q <= stored_q & KEEP;
        else if (wr_en)
            stored_q <= wdata & WMASK;
    end

    // Put the identification code on top of the stored bits.
    always_comb begin
        q = stored_q;
        q[31:28] = ID;
    end

    assign ce_irq_en = stored_q[1];

    AST_EN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & ~(WMASK | 32'hF000_0000)) == 32'h0)); // R2
endmodule

// File: rtl/ecc_fault_unit.sv
// Fault status, fault address registers and the error interrupt.
// A capture strobe takes priority over a same-cycle bus write to status.
// Assumes a synchronous active-low reset.
module ecc_fault_unit
    import ecc_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        st_wr,
    input  logic [31:0] st_wdata,
    input  logic        flt_valid,
    input  logic        flt_ue,
    input  logic [3:0]  flt_dw,
    input  logic [7:0]  flt_synd,
    input  logic [31:0] flt_addr0,
    input  logic [31:0] flt_addr1,
    input  logic        ce_irq_en,
    output logic [31:0] status_q,
    output logic [31:0] fa0_q,
    output logic [31:0] fa1_q,
    output logic        irq
);
    logic [31:0] cap_word;
    logic        raise;
    logic        irq_next;

    // Assemble the captured status word and the multiple-error flag.
    always_comb begin
        cap_word        = '0;
        cap_word[0]     = ~flt_ue;
        cap_word[3]     = flt_ue;
        cap_word[7:4]   = flt_dw;
        cap_word[15:8]  = flt_synd;
        cap_word[16]    = status_q[0] | status_q[3];
    end

    // Decide the next interrupt level: capture raise, then write clear.
    always_comb begin
        raise = flt_valid & (flt_ue | ce_irq_en);
        if (raise)
            irq_next = 1'b1;
        else if (st_wr)
            irq_next = 1'b0;
        else
            irq_next = irq;
    end

    // Register status, fault addresses and the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            fa0_q    <= FA0_RESET;
            fa1_q    <= '0;
            irq      <= 1'b0;
        end else begin
            irq <= irq_next;
            if (flt_valid) begin
                status_q <= cap_word;
                fa0_q    <= flt_addr0;
                fa1_q    <= flt_addr1;
            end else if (st_wr) begin
                status_q <= st_wdata;
            end
        end
    end

    AST_STS_WR_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !flt_valid) |=> !irq); // R4
    AST_FA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |=> ($stable(fa0_q) && $stable(fa1_q))); // R5
    AST_ME_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && (status_q[0] || status_q[3])) |=> status_q[16]); // R10
    AST_UE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_ue) |=> irq); // R11
    AST_CE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_ue && !ce_irq_en && !irq) |=> !irq); // R11
endmodule

// File: rtl/ecc_diag_window.sv
// Byte-wide diagnostic store of DEPTH entries. One byte is written per
// access and read combinationally. Assumes a synchronous active-low reset.
module ecc_diag_window #(
    parameter int DEPTH = 4,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] mem_q [DEPTH];

    // Clear every entry on reset, or update the selected byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (wr_en) begin
            mem_q[sel] <= wdata;
        end
    end

    assign rdata = mem_q[sel];
endmodule

// File: rtl/ecc_ctl_regs.sv
// Top of the ECC controller register file: address decode, plain data
// registers, read multiplexer, and the variant-0 diagnostic window.
// Assumes ADDR_W >= 13 and a synchronous active-low reset.
module ecc_ctl_regs
    import ecc_regs_pkg::*;
#(
    parameter int VARIANT = 2,
    parameter int ADDR_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              flt_valid,
    input  logic              flt_ue,
    input  logic [3:0]        flt_dw,
    input  logic [7:0]        flt_synd,
    input  logic [31:0]       flt_addr0,
    input  logic [31:0]       flt_addr1,
    output logic              irq
);
    localparam int WIN_BIT = ADDR_W - 1;
    localparam int IDX_W   = ADDR_W - 3;
    localparam int PLAIN_N = 4;

    logic [IDX_W-1:0] idx;
    logic             reg_acc;
    logic             reg_wr;
    logic             win_acc;
    logic [31:0]      en_q, dly_q, sts_q, fa0_q, fa1_q;
    logic [31:0]      plain_q [PLAIN_N];
    logic             ce_irq_en;
    logic [7:0]       diag_rd;

    // Map each plain register slot to its word index.
    function automatic int plain_idx(input int k);
        case (k)
            0:       return IDX_VID;
            1:       return IDX_DIAG;
            2:       return IDX_EV0;
            default: return IDX_EV1;
        endcase
    endfunction

    assign idx     = bus_addr[WIN_BIT-1:2];
    assign reg_acc = !bus_addr[WIN_BIT] && !bus_byte;
    assign reg_wr  = bus_sel && bus_wr && reg_acc;
    assign win_acc = bus_addr[WIN_BIT] && bus_byte && (idx == '0);

    ecc_enable_reg #(.VARIANT(VARIANT)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && idx == IDX_W'(IDX_EN)),
        .wdata     (bus_wdata),
        .q         (en_q),
        .ce_irq_en (ce_irq_en)
    );

    ecc_fault_unit u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_wr     (reg_wr && idx == IDX_W'(IDX_STS)),
        .st_wdata  (bus_wdata),
        .flt_valid (flt_valid),
        .flt_ue    (flt_ue),
        .flt_dw    (flt_dw),
        .flt_synd  (flt_synd),
        .flt_addr0 (flt_addr0),
        .flt_addr1 (flt_addr1),
        .ce_irq_en (ce_irq_en),
        .status_q  (sts_q),
        .fa0_q     (fa0_q),
        .fa1_q     (fa1_q),
        .irq       (irq)
    );

    // Delay register: bit 31 is always stored as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly_q <= DLY_RESET;
        else if (reg_wr && idx == IDX_W'(IDX_DLY))
            dly_q <= bus_wdata & DLY_WMASK;
    end

    // Full-width registers without side effects.
    for (genvar g = 0; g < PLAIN_N; g++) begin : gen_plain
        always_ff @(posedge clk) begin
            if (!rst_n)
                plain_q[g] <= '0;
            else if (reg_wr && idx == IDX_W'(plain_idx(g)))
                plain_q[g] <= bus_wdata;
        end
    end

    // Diagnostic byte window, present on variant 0 only.
    if (VARIANT == 0) begin : gen_diag
        ecc_diag_window #(.DEPTH(4)) u_diag (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_sel && bus_wr && win_acc),
            .sel   (bus_addr[1:0]),
            .wdata (bus_wdata[7:0]),
            .rdata (diag_rd)
        );
    end else begin : gen_no_diag
        assign diag_rd = '0;
    end

    // Read multiplexer: unmapped space returns zero.
    always_comb begin
        bus_rdata = '0;
        if (reg_acc) begin
            case (idx)
                IDX_W'(IDX_EN):   bus_rdata = en_q;
                IDX_W'(IDX_DLY):  bus_rdata = dly_q;
                IDX_W'(IDX_STS):  bus_rdata = sts_q;
                IDX_W'(IDX_VID):  bus_rdata = plain_q[0];
                IDX_W'(IDX_FA0):  bus_rdata = fa0_q;
                IDX_W'(IDX_FA1):  bus_rdata = fa1_q;
                IDX_W'(IDX_DIAG): bus_rdata = plain_q[1];
                IDX_W'(IDX_EV0):  bus_rdata = plain_q[2];
                IDX_W'(IDX_EV1):  bus_rdata = plain_q[3];
                default:          bus_rdata = '0;
            endcase
        end else if (win_acc) begin
            bus_rdata = {24'h0, diag_rd};
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && reg_acc && idx > IDX_W'(NUM_REGS - 1)) |-> (bus_rdata == 32'h0)); // R13
    AST_ID_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && reg_acc && idx == IDX_W'(IDX_EN)) |-> (bus_rdata[31:28] == id_code(VARIANT))); // R2
    AST_DLY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dly_q == DLY_RESET)); // R7
    AST_DLY_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && reg_acc && idx == IDX_W'(IDX_DLY)) |-> !bus_rdata[31]); // R3
endmodule

// File: tb/ecc_ctl_regs_test.sv
module ecc_ctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        flt_valid = 1'b0, flt_ue = 1'b0;
    logic [3:0]  flt_dw = '0;
    logic [7:0]  flt_synd = '0;
    logic [31:0] flt_addr0 = '0, flt_addr1 = '0;
    logic [31:0] rd0, rd2;
    logic        irq0, irq2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model: slot 0 is the variant-0 instance, slot 1 the variant-2 instance.
    logic [31:0] mreg [2][9];
    logic [7:0]  mdiag [4];
    bit          mirq [2];

    always #4 clk = ~clk;

    ecc_ctl_regs #(.VARIANT(0), .ADDR_W(13)) uut_v0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd0), .flt_valid(flt_valid), .flt_ue(flt_ue),
        .flt_dw(flt_dw), .flt_synd(flt_synd), .flt_addr0(flt_addr0),
        .flt_addr1(flt_addr1), .irq(irq0));

    ecc_ctl_regs #(.VARIANT(2), .ADDR_W(13)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd2), .flt_valid(flt_valid), .flt_ue(flt_ue),
        .flt_dw(flt_dw), .flt_synd(flt_synd), .flt_addr0(flt_addr0),
        .flt_addr1(flt_addr1), .irq(irq2));

    function automatic logic [31:0] exp_read(int v, logic [12:0] a, bit byt);
        int i;
        if (a[12]) begin
            if (v == 0 && byt && a[11:2] == 0) return {24'h0, mdiag[a[1:0]]};
            return 32'h0;
        end
        if (byt) return 32'h0;
        i = int'(a[11:2]);
        if (i > 8) return 32'h0;
        if (i == 0 && v == 1) return mreg[v][0] | 32'h2000_0000;
        return mreg[v][i];
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        mreg[0][0] = mreg[0][0] & 32'h0000_0100;
        mreg[1][0] = mreg[1][0] & 32'h0000_0BFC;
        for (int v = 0; v < 2; v++) begin
            for (int i = 1; i < 9; i++) mreg[v][i] = 32'h0;
            mreg[v][1] = 32'h20;
            mreg[v][4] = 32'h07C0_0000;
            mirq[v] = 1'b0;
        end
        for (int k = 0; k < 4; k++) mdiag[k] = 8'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(logic [12:0] a, logic [31:0] d, bit byt);
        int i;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_byte = byt; bus_addr = a; bus_wdata = d;
        i = int'(a[11:2]);
        if (a[12]) begin
            if (byt && i == 0) mdiag[a[1:0]] = d[7:0];
        end else if (!byt) begin
            for (int v = 0; v < 2; v++) begin
                case (i)
                    0: mreg[v][0] = d & ((v == 0) ? 32'h0000_0103 : 32'h0000_0BFF);
                    1: mreg[v][1] = d & 32'h7FFF_FFFF;
                    2: begin mreg[v][2] = d; mirq[v] = 1'b0; end
                    3, 6, 7, 8: mreg[v][i] = d;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic check_read(logic [12:0] a, bit byt, string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_byte = byt; bus_addr = a;
        #2;
        check32({tag, " v0"}, rd0, exp_read(0, a, byt));
        check32({tag, " v2"}, rd2, exp_read(1, a, byt));
        bus_sel = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic check_irq(string tag);
        check32({tag, " irq v0"}, {31'h0, irq0}, {31'h0, mirq[0]});
        check32({tag, " irq v2"}, {31'h0, irq2}, {31'h0, mirq[1]});
    endtask

    task automatic capture(bit ue, logic [3:0] dw, logic [7:0] syn,
                           logic [31:0] a0, logic [31:0] a1);
        @(negedge clk);
        flt_valid = 1'b1; flt_ue = ue; flt_dw = dw; flt_synd = syn;
        flt_addr0 = a0; flt_addr1 = a1;
        for (int v = 0; v < 2; v++) begin
            logic me;
            me = mreg[v][2][0] | mreg[v][2][3];
            mreg[v][2] = {15'h0, me, syn, dw, ue, 2'b00, ~ue};
            mreg[v][4] = a0;
            mreg[v][5] = a1;
            if (ue || mreg[v][0][1]) mirq[v] = 1'b1;
        end
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            check_read(13'(i * 4), 1'b0, tag);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int v = 0; v < 2; v++) mreg[v][0] = 32'h0;
        do_reset();

        // R7 reset values, R6 power-up enable, R1 layout
        sweep("R7 reset");
        check_irq("R7 reset");

        // R2 masks and identification field
        bus_write(13'h000, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk); check_read(13'h000, 1'b0, "R2 enable all-ones");
        // R6 reset retention
        do_reset();
        @(negedge clk); check_read(13'h000, 1'b0, "R6 retention");

        // R3 delay bit 31
        bus_write(13'h004, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk); check_read(13'h004, 1'b0, "R3 delay");

        // R12 independent event counters
        bus_write(13'h01C, 32'h1111_AAAA, 1'b0);
        bus_write(13'h020, 32'h2222_5555, 1'b0);
        @(negedge clk); check_read(13'h01C, 1'b0, "R12 ev0");
        @(negedge clk); check_read(13'h020, 1'b0, "R12 ev1");

        // R5 fault address writes ignored
        bus_write(13'h010, 32'hDEAD_BEEF, 1'b0);
        bus_write(13'h014, 32'hCAFE_F00D, 1'b0);
        @(negedge clk); check_read(13'h010, 1'b0, "R5 fa0");
        @(negedge clk); check_read(13'h014, 1'b0, "R5 fa1");

        // R13 unmapped and byte accesses
        bus_write(13'h024, 32'h1234_5678, 1'b0);
        bus_write(13'h00C, 32'h8765_4321, 1'b1);
        @(negedge clk); check_read(13'h024, 1'b0, "R13 unmapped");
        @(negedge clk); check_read(13'h00C, 1'b1, "R13 byte to reg");
        @(negedge clk); check_read(13'h00C, 1'b0, "R13 video kept");

        // R8 diagnostic window
        for (int k = 0; k < 4; k++) bus_write(13'h1000 + 13'(k), 32'hA0 + 32'(k), 1'b1);
        bus_write(13'h1000, 32'hFFFF_FFFF, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); check_read(13'h1000 + 13'(k), 1'b1, "R8 diag byte");
        end
        @(negedge clk); check_read(13'h1000, 1'b0, "R8 diag word");

        // R11 correctable masked, then enabled; R9 layout; R10 multiple error
        bus_write(13'h000, 32'h0, 1'b0);
        capture(1'b0, 4'h5, 8'h3C, 32'h0000_1000, 32'h0000_0002);
        check_irq("R11 ce masked");
        @(negedge clk); check_read(13'h008, 1'b0, "R9 status ce");
        @(negedge clk); check_read(13'h010, 1'b0, "R9 fa0");
        capture(1'b1, 4'hA, 8'hC3, 32'h1234_0000, 32'h0000_0009);
        check_irq("R11 ue");
        @(negedge clk); check_read(13'h008, 1'b0, "R10 multiple");
        bus_write(13'h008, 32'h0F0F_0F0F, 1'b0);
        check_irq("R4 clear");
        @(negedge clk); check_read(13'h008, 1'b0, "R4 stored");
        bus_write(13'h000, 32'h2, 1'b0);
        bus_write(13'h008, 32'h0, 1'b0);
        capture(1'b0, 4'h1, 8'h11, 32'h0, 32'h0);
        check_irq("R11 ce enabled");
        @(negedge clk); check_read(13'h008, 1'b0, "R10 no multiple");

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: bus_write(13'(($urandom % 12) * 4), $urandom, 1'b0);
                1: capture(1'($urandom), 4'($urandom), 8'($urandom), $urandom, $urandom);
                2: begin @(negedge clk); check_read(13'(($urandom % 16) * 4), 1'($urandom % 2), "R1 random read"); end
                default: begin
                    bus_write(13'h1000 + 13'($urandom % 4), $urandom, 1'b1);
                    @(negedge clk); check_read(13'h1000 + 13'($urandom % 4), 1'b1, "R8 random diag");
                end
            endcase
            check_irq("R11 random");
        end
        sweep("R1 final");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule